// File: doc/BRIEF.md
# Nibble-Addressed Multiply/Divide Unit

This unit is an arithmetic helper that sits on a 4-bit register bus. It performs an unsigned 8x8 multiply or an unsigned 16-by-8 divide. Software loads the operands one nibble at a time into a destination pair and a source byte. The destination pair is a high byte and a low byte, each reached through two nibble addresses. Writing the control nibble selects the operation and starts it.

The unit then stays busy for a fixed number of clock cycles. When it finishes, it writes the result back in place into the destination pair and updates three result flags: negative, overflow and zero. A divide that overflows changes neither destination byte. The busy indication is bit 0 of the control nibble, the same bit whose written value picks the operation.

Top module: `mdu_top`

## Requirements
- R1: After reset, the control nibble at address 6 reads 0: not busy and all flags clear.
- R2: Address map for the data bytes, with the lower nibble at the lower address:
  - destination low byte: bits 3:0 at address 0, bits 7:4 at address 1;
  - destination high byte: bits 3:0 at address 2, bits 7:4 at address 3;
  - source byte: bits 3:0 at address 4, bits 7:4 at address 5.
  - `rd_data` is registered and shows the addressed nibble one clock after the address is presented.
- R3: A write to address 6 starts an operation. Bit 0 of the control nibble then reads 1 for exactly LATENCY (default 10) clock cycles and returns to 0 in the cycle the results land.
- R4: Writing 0 in bit 0 of the control nibble starts a multiply. The high byte of the product (low byte times source) goes to the destination high byte and the low byte of the product goes to the destination low byte. The previous contents of the destination high byte do not affect the result.
- R5: Writing 1 in bit 0 of the control nibble starts a divide of {high byte, low byte} by the source byte. The quotient goes to the destination low byte and the remainder goes to the destination high byte.
- R6: A divide overflows when the source is zero or the high byte is greater than or equal to the source. On overflow:
  - both destination bytes keep their previous values;
  - the overflow flag is set;
  - the negative and zero flags are cleared.
- R7: A completed multiply always clears the overflow flag.
- R8: The negative flag is the MSB of the result (product bit 15, or quotient bit 7). The zero flag is set when the result is zero.
- R9: The control nibble reads {negative, overflow, zero, busy} in bits 3..0. Bits 3:1 are read-only: values written to them have no effect on the flags.
- R10: While the unit is busy, writes to any address are ignored, including a second write to the control nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed nibble |
| addr | input | 3 | Nibble address |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Registered read data |

## Verification
Some behaviours are checked by assertions on every cycle:
- the busy window counts down one step per cycle and always ends;
- operands and flags stay frozen while an operation runs;
- an overflowing divide leaves both destination bytes unchanged;
- a finished multiply leaves the overflow flag clear;
- every accepted divide produces a remainder smaller than the divisor.

The actual product and quotient values, the nibble address map and the exact ten-cycle busy length seen on the bus can only be shown by the bench scenarios. These scenarios also cover the read-only flag bits and the writes made while the unit is busy.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int NIB_W        = 4;
  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = 3;
  localparam int NIB_PER_BYTE = BYTE_W / NIB_W;

  // nibble address bases; lower nibble sits at the base address
  localparam int A_LO_BASE  = 0;
  localparam int A_HI_BASE  = 2;
  localparam int A_SRC_BASE = 4;
  localparam int A_CTRL     = 6;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
  } flags_t;
endpackage

// File: rtl/mdu_calc.sv
module mdu_calc
  import mdu_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         op_div,
  input  logic [W-1:0] dst_hi,
  input  logic [W-1:0] dst_lo,
  input  logic [W-1:0] src,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output flags_t       flags,
  output logic         write_back
);
  localparam int DW = 2 * W;

  logic [DW-1:0] prod;
  logic [DW-1:0] dividend;
  logic [W-1:0]  divisor;
  logic [W-1:0]  quo;
  logic [W-1:0]  rem;
  logic          div_ovf;

  always_comb begin
    prod     = DW'(dst_lo) * DW'(src);
    dividend = {dst_hi, dst_lo};
    div_ovf  = (src == '0) || (dst_hi >= src);
    divisor  = div_ovf ? W'(1) : src;
    quo      = W'(dividend / DW'(divisor));
    rem      = W'(dividend % DW'(divisor));
    if (op_div) begin
      res_hi     = rem;
      res_lo     = quo;
      write_back = !div_ovf;
      flags.ovf  = div_ovf;
      flags.neg  = !div_ovf && quo[W-1];
      flags.zero = !div_ovf && (quo == '0);
    end else begin
      res_hi     = prod[DW-1:W];
      res_lo     = prod[W-1:0];
      write_back = 1'b1;
      flags.ovf  = 1'b0;
      flags.neg  = prod[DW-1];
      flags.zero = (prod == '0);
    end
  end

  // R5: an accepted divide always leaves a remainder below the divisor
  always_comb begin
    if (op_div && write_back) begin
      p_rem_bound_r5: assert (rem < src);
    end
  end
endmodule

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter int LATENCY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(LATENCY - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && (cnt == CNT_W'(LATENCY - 1)));
  p_count_r3: assert property (@(posedge clk) disable iff (rst)
    busy && (cnt != '0) |=> busy && (cnt == $past(cnt) - 1'b1));
  p_end_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  wr_data,
  output logic [NIB_W-1:0]  rd_data
);
  logic [BYTE_W-1:0] dst_hi, dst_lo, src;
  logic [BYTE_W-1:0] res_hi, res_lo;
  flags_t            flags, res_flags;
  logic              op_div, write_back;
  logic              busy, done, wr_ok, start;

  assign wr_ok = wr_en && !busy;
  assign start = wr_ok && (addr == ADDR_W'(A_CTRL));

  mdu_seq #(.LATENCY(LATENCY)) seq_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
  );

  mdu_calc #(.W(BYTE_W)) calc_i (
    .op_div(op_div), .dst_hi(dst_hi), .dst_lo(dst_lo), .src(src),
    .res_hi(res_hi), .res_lo(res_lo), .flags(res_flags),
    .write_back(write_back)
  );

  // operand registers: not reset, contents undefined until written
  always_ff @(posedge clk) begin
    if (done) begin
      if (write_back) begin
        dst_hi <= res_hi;
        dst_lo <= res_lo;
      end
    end else if (wr_ok) begin
      for (int i = 0; i < NIB_PER_BYTE; i++) begin
        if (addr == ADDR_W'(A_LO_BASE + i))  dst_lo[i*NIB_W +: NIB_W] <= wr_data;
        if (addr == ADDR_W'(A_HI_BASE + i))  dst_hi[i*NIB_W +: NIB_W] <= wr_data;
        if (addr == ADDR_W'(A_SRC_BASE + i)) src[i*NIB_W +: NIB_W]    <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      op_div <= 1'b0;
    end else begin
      if (start) op_div <= wr_data[0];
      if (done)  flags  <= res_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int i = 0; i < NIB_PER_BYTE; i++) begin
        if (addr == ADDR_W'(A_LO_BASE + i))  rd_data <= dst_lo[i*NIB_W +: NIB_W];
        if (addr == ADDR_W'(A_HI_BASE + i))  rd_data <= dst_hi[i*NIB_W +: NIB_W];
        if (addr == ADDR_W'(A_SRC_BASE + i)) rd_data <= src[i*NIB_W +: NIB_W];
      end
      if (addr == ADDR_W'(A_CTRL)) rd_data <= {flags.neg, flags.ovf, flags.zero, busy};
    end
  end

  p_busy_lock_r10: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> $stable(dst_hi) && $stable(dst_lo) && $stable(src) && $stable(op_div));
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> $stable(flags));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    done && !op_div |=> !flags.ovf);
  p_ovf_keep_r6: assert property (@(posedge clk) disable iff (rst)
    done && op_div && !write_back |=> $stable(dst_hi) && $stable(dst_lo) && flags.ovf);
endmodule

// File: tb/mdu_top_tb_top.sv
`timescale 1ns/1ps
module mdu_top_tb_top;
  logic       clk = 1'b0;
  logic       rst, wr_en;
  logic [2:0] addr;
  logic [3:0] wr_data, rd_data;

  always #4 clk = ~clk;

  mdu_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  typedef struct {
    logic [7:0] hi;
    logic [7:0] lo;
    logic [3:0] ctrl;
    string      tag;
  } item_t;

  item_t exp_q[$];
  item_t act_q[$];
  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [3:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic set_byte(logic [2:0] base, logic [7:0] v);
    wr(base, v[3:0]);
    wr(base + 3'd1, v[7:4]);
  endtask

  task automatic get_byte(logic [2:0] base, output logic [7:0] v);
    logic [3:0] n0, n1;
    rd(base, n0);
    rd(base + 3'd1, n1);
    v = {n1, n0};
  endtask

  // driver: loads operands, pushes the expected item, runs, pushes the observed item
  task automatic run_op(bit dv, logic [7:0] hi, logic [7:0] lo, logic [7:0] s,
                        logic [2:0] junk, bit poke, string tag);
    item_t e, a;
    logic [15:0] p, q, r;
    int cnt;
    set_byte(3'd2, hi);
    set_byte(3'd0, lo);
    set_byte(3'd4, s);
    e.tag = tag;
    if (!dv) begin
      p = 16'(lo) * 16'(s);
      e.hi = p[15:8]; e.lo = p[7:0];
      e.ctrl = {p[15], 1'b0, p == 16'd0, 1'b0};
    end else if (s == 8'd0 || hi >= s) begin
      e.hi = hi; e.lo = lo; e.ctrl = 4'b0100;
    end else begin
      q = {hi, lo} / 16'(s);
      r = {hi, lo} % 16'(s);
      e.hi = r[7:0]; e.lo = q[7:0];
      e.ctrl = {q[7], 1'b0, q[7:0] == 8'd0, 1'b0};
    end
    exp_q.push_back(e);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd6; wr_data = {junk, dv};
    @(negedge clk);
    wr_en = 1'b0;
    if (poke) begin
      // R10: writes while busy must not disturb operands or restart the unit
      wr_en = 1'b1; addr = 3'd0; wr_data = 4'hF;
      @(negedge clk); addr = 3'd4; wr_data = 4'h1;
      @(negedge clk); addr = 3'd6; wr_data = 4'h0;
      @(negedge clk); wr_en = 1'b0;
      repeat (12) @(negedge clk);
    end else begin
      cnt = 0;
      repeat (14) begin
        @(negedge clk);
        if (rd_data[0]) cnt++;
      end
      check({"R3 busy length ", tag}, 16'(cnt), 16'd10);
    end
    get_byte(3'd2, a.hi);
    get_byte(3'd0, a.lo);
    rd(3'd6, a.ctrl);
    a.tag = tag;
    act_q.push_back(a);
  endtask

  // monitor: compares observed results against the expected queue
  initial begin
    item_t e, a;
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        a = act_q.pop_front();
        check({e.tag, " hi"},   16'(a.hi),   16'(e.hi));
        check({e.tag, " lo"},   16'(a.lo),   16'(e.lo));
        check({e.tag, " ctrl"}, 16'(a.ctrl), 16'(e.ctrl));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] n;
    logic [7:0] b;
    rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    rd(3'd6, n);
    check("R1 reset ctrl", 16'(n), 16'h0);

    set_byte(3'd0, 8'hA5);
    set_byte(3'd2, 8'h3C);
    set_byte(3'd4, 8'h96);
    rd(3'd0, n); check("R2 lo nibble0", 16'(n), 16'h5);
    rd(3'd1, n); check("R2 lo nibble1", 16'(n), 16'hA);
    rd(3'd2, n); check("R2 hi nibble0", 16'(n), 16'hC);
    rd(3'd3, n); check("R2 hi nibble1", 16'(n), 16'h3);
    get_byte(3'd4, b); check("R2 src byte", 16'(b), 16'h96);

    run_op(1'b0, 8'h77, 8'hFF, 8'hFF, 3'b000, 1'b0, "R4 R8 mul ff*ff");
    run_op(1'b0, 8'hEE, 8'd12, 8'd10, 3'b000, 1'b0, "R4 mul 12*10");
    run_op(1'b1, 8'h12, 8'h34, 8'h56, 3'b000, 1'b0, "R5 div 1234/56");
    run_op(1'b1, 8'h7F, 8'hFF, 8'h80, 3'b000, 1'b0, "R5 R8 div neg quotient");
    run_op(1'b1, 8'h00, 8'h03, 8'h10, 3'b000, 1'b0, "R5 R8 div zero quotient");
    run_op(1'b1, 8'h12, 8'h34, 8'h00, 3'b000, 1'b0, "R6 div by zero");
    run_op(1'b1, 8'h50, 8'h00, 8'h50, 3'b000, 1'b0, "R6 div hi equals src");
    run_op(1'b0, 8'h01, 8'h02, 8'h03, 3'b000, 1'b0, "R7 mul clears ovf");
    run_op(1'b0, 8'hFF, 8'h05, 8'h00, 3'b111, 1'b0, "R9 flag bits read-only");
    run_op(1'b1, 8'h12, 8'h34, 8'h56, 3'b000, 1'b1, "R10 writes while busy");

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule